// File: doc/BRIEF.md
# Card Strobe Setup/Hold Wait Sequencer

This block generates the address-valid, read-strobe and write-strobe timing for one access on a PC Card (PCMCIA) style external bus. After it accepts a request it drives the address. It then waits a programmed number of cycles before it lowers the strobe. The strobe stays low for a given width. After the strobe rises, the address is held for a programmed number of cycles. A one-cycle completion pulse ends the access.

Two timing sets are programmed, each with a setup field and a hold field of 3 bits. A timing-select bit that comes with each request picks the set. A field does not count waits linearly: the codes 0 to 7 give 0, 1, 2, 3, 6, 9, 12 and 15 cycles. The request type decides which strobe moves, and whether a data-sample pulse is given. For a memory read, the hold time counts from the sample point and not from strobe release.

Top module: `card_strobe_seq`

## Requirements
- R1: A 3-bit setup or hold code maps to a wait count as follows: 0→0, 1→1, 2→2, 3→3, 4→6, 5→9, 6→12, 7→15.
- R2: After the accepting edge, `addr_valid` is high for exactly the decoded setup count of cycles before a strobe goes low. With a setup count of 0, the strobe is low in the first cycle of the access.
- R3: When `req_tc` is 1, the codes `setup_code1`/`hold_code1` are used. When it is 0, `setup_code0`/`hold_code0` are used.
- R4: A strobe stays low for `strobe_width` consecutive cycles. A width of 0 is treated as 1.
- R5: `req_kind` bit 0 is 1 for a write and 0 for a read. Bit 1 is 1 for I/O and 0 for memory. A read lowers only `oe_n` and a write lowers only `we_n`. Both strobes are active low and are high outside the strobe window.
- R6: On a read, `sample` is high only in the last strobe-low cycle. On a write, `sample` is never high.
- R7: For writes and I/O reads, `addr_valid` stays high for the decoded hold count of cycles after the strobe rises.
- R8: For a memory read, the sample cycle is the first hold cycle. `addr_valid` therefore stays high for max(hold−1, 0) cycles after `oe_n` rises.
- R9: `done` is high for one cycle right after `addr_valid` falls, with both strobes high. A request that is present only in the `done` cycle is ignored. A request can be accepted from the next cycle on.
- R10: The select bit, type, width and codes are captured at acceptance. Changes to them during an access do not alter that access.
- R11: During and after reset with no request, `addr_valid`, `sample` and `done` are 0 and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken when the sequencer is idle |
| req_kind | input | 2 | bit0 write, bit1 I/O space |
| req_tc | input | 1 | Timing-set select |
| strobe_width | input | WIDTH_W | Strobe-low cycles (0 acts as 1) |
| setup_code0 | input | 3 | Set 0 address-to-strobe code |
| hold_code0 | input | 3 | Set 0 strobe-to-release code |
| setup_code1 | input | 3 | Set 1 address-to-strobe code |
| hold_code1 | input | 3 | Set 1 strobe-to-release code |
| addr_valid | output | 1 | Address driven |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| sample | output | 1 | Read data capture pulse |
| done | output | 1 | Access complete pulse |

## Verification
All outputs come from state registers. The first cycle of an access can therefore be seen one edge after the edge that samples `req_valid`. From then on, every cycle follows a fixed pattern: setup cycles, then width cycles, then hold cycles, then one `done` cycle. The driver turns each request into this full cycle-by-cycle pattern of the five outputs. The monitor compares one entry at each falling edge, starting one falling edge after the request is raised. When no entry is pending, the monitor checks for idle outputs, so any extra or missing cycle shows up as a mismatch.

// File: rtl/cs_pkg.sv
// Shared types for the card strobe sequencer.
// Assumes 3-bit delay codes and 4-bit decoded wait counts (max 15).
package cs_pkg;
    localparam int CODE_W = 3;
    localparam int WAIT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic io;   // 1: I/O space, 0: memory space
        logic wr;   // 1: write, 0: read
    } acc_kind_t;
endpackage

// File: rtl/cs_wait_decode.sv
// Maps a 3-bit delay code onto its wait count: codes 0-3 are literal,
// codes 4-7 step by three (6, 9, 12, 15). Purely combinational.
module cs_wait_decode
    import cs_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [WAIT_W-1:0] waits
);
    // Linear region below 4, then three cycles per step
    always_comb begin
        if (code[2]) waits = WAIT_W'(3 * ({1'b0, code} - 4'd2));
        else         waits = WAIT_W'(code);
    end
endmodule

// File: rtl/cs_down_counter.sv
// Phase length counter: loads (length - 1) on phase entry and counts
// down to zero; the phase ends in the cycle where zero is flagged.
module cs_down_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);
endmodule

// File: rtl/card_strobe_seq.sv
// Card bus strobe sequencer. Accepts one access at a time while idle,
// captures its timing set, then steps setup -> strobe -> hold -> done.
// Assumes the requester holds no expectations of back-pressure: a request
// seen outside the idle state is simply not taken.
module card_strobe_seq
    import cs_pkg::*;
#(
    parameter int WIDTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic               req_tc,
    input  logic [WIDTH_W-1:0] strobe_width,
    input  logic [CODE_W-1:0]  setup_code0,
    input  logic [CODE_W-1:0]  hold_code0,
    input  logic [CODE_W-1:0]  setup_code1,
    input  logic [CODE_W-1:0]  hold_code1,
    output logic               addr_valid,
    output logic               oe_n,
    output logic               we_n,
    output logic               sample,
    output logic               done
);
    localparam int CNT_W   = (WIDTH_W > WAIT_W) ? WIDTH_W : WAIT_W;
    localparam int N_FIELD = 2;   // index 0: setup, index 1: hold

    seq_state_t       state, nxt_state;
    acc_kind_t        live_kind, lat_kind;
    logic [CNT_W-1:0] lat_width, lat_hold;
    logic [CNT_W-1:0] live_width, live_hold, live_setup;
    logic [CNT_W-1:0] ld_val;
    logic             ld, cnt_zero, accept, live_mem_rd;

    logic [CODE_W-1:0] set0_code [N_FIELD];
    logic [CODE_W-1:0] set1_code [N_FIELD];
    logic [WAIT_W-1:0] dec_waits [N_FIELD];

    assign set0_code[0] = setup_code0;
    assign set0_code[1] = hold_code0;
    assign set1_code[0] = setup_code1;
    assign set1_code[1] = hold_code1;

    // One decoder per field, fed by the set the request selects
    for (genvar gi = 0; gi < N_FIELD; gi++) begin : g_field
        logic [CODE_W-1:0] sel_code;
        assign sel_code = req_tc ? set1_code[gi] : set0_code[gi];
        cs_wait_decode u_dec (
            .code  (sel_code),
            .waits (dec_waits[gi])
        );
    end

    assign live_kind   = acc_kind_t'(req_kind);
    assign live_mem_rd = !live_kind.io && !live_kind.wr;
    assign live_setup  = CNT_W'(dec_waits[0]);
    assign live_width  = (strobe_width == '0) ? CNT_W'(1) : CNT_W'(strobe_width);
    // Memory reads count hold from the sample cycle, which is itself one hold cycle
    assign live_hold   = (live_mem_rd && dec_waits[1] != '0)
                         ? CNT_W'(dec_waits[1] - 1'b1) : CNT_W'(dec_waits[1]);
    assign accept      = (state == ST_IDLE) && req_valid;

    // Capture the access parameters at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_kind  <= '0;
            lat_width <= CNT_W'(1);
            lat_hold  <= '0;
        end else if (accept) begin
            lat_kind  <= live_kind;
            lat_width <= live_width;
            lat_hold  <= live_hold;
        end
    end

    // Phase transitions and counter loads
    always_comb begin
        nxt_state = state;
        ld        = 1'b0;
        ld_val    = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                ld = 1'b1;
                if (live_setup != '0) begin
                    nxt_state = ST_SETUP;
                    ld_val    = live_setup - 1'b1;
                end else begin
                    nxt_state = ST_STROBE;
                    ld_val    = live_width - 1'b1;
                end
            end
            ST_SETUP: if (cnt_zero) begin
                nxt_state = ST_STROBE;
                ld        = 1'b1;
                ld_val    = lat_width - 1'b1;
            end
            ST_STROBE: if (cnt_zero) begin
                if (lat_hold != '0) begin
                    nxt_state = ST_HOLD;
                    ld        = 1'b1;
                    ld_val    = lat_hold - 1'b1;
                end else begin
                    nxt_state = ST_DONE;
                end
            end
            ST_HOLD: if (cnt_zero) nxt_state = ST_DONE;
            ST_DONE: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    cs_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .is_zero  (cnt_zero)
    );

    // Output decode from registered state only
    always_comb begin
        addr_valid = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        oe_n       = !((state == ST_STROBE) && !lat_kind.wr);
        we_n       = !((state == ST_STROBE) &&  lat_kind.wr);
        sample     = (state == ST_STROBE) && !lat_kind.wr && cnt_zero;
        done       = (state == ST_DONE);
    end
endmodule

// File: rtl/card_strobe_seq_chk.sv
// Port-level protocol checks for card_strobe_seq, attached by bind.
module card_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic addr_valid,
    input logic oe_n,
    input logic we_n,
    input logic sample,
    input logic done
);
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
    assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> addr_valid);
    assert_sample_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (!oe_n && we_n));
    assert_sample_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> oe_n);
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!addr_valid && oe_n && we_n));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !addr_valid));
    assert_start_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(req_valid));
endmodule

bind card_strobe_seq card_strobe_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .addr_valid (addr_valid),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .sample     (sample),
    .done       (done)
);

// File: tb/card_strobe_seq_tb.sv
// Scoreboard bench: the driver expands each request into its expected
// per-cycle output pattern; the monitor compares one entry per falling edge.
module card_strobe_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic       req_tc = 1'b0;
    logic [3:0] strobe_width = 4'd1;
    logic [2:0] setup_code0 = '0, hold_code0 = '0, setup_code1 = '0, hold_code1 = '0;
    logic addr_valid, oe_n, we_n, sample, done;

    typedef struct {
        logic  av, oe, we, smp, dn;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0, n_fail = 0;
    bit    mon_on = 1'b0;
    string idle_tag = "R11";

    always #10 clk = ~clk;   // 50 MHz

    card_strobe_seq u_dut (
        .clk, .rst_n, .req_valid, .req_kind, .req_tc, .strobe_width,
        .setup_code0, .hold_code0, .setup_code1, .hold_code1,
        .addr_valid, .oe_n, .we_n, .sample, .done
    );

    function automatic int dec(input logic [2:0] c);
        case (c)
            3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 3;
            3'd4: return 6;  3'd5: return 9;  3'd6: return 12; default: return 15;
        endcase
    endfunction

    task automatic cmp(input string tag, input string nm, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, expv, $time);
        end
    endtask

    // Monitor: one expected entry per cycle, idle outputs otherwise
    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = '{av:1'b0, oe:1'b1, we:1'b1, smp:1'b0, dn:1'b0, tag:idle_tag};
            cmp(e.tag, "addr_valid", addr_valid, e.av);
            cmp(e.tag, "oe_n", oe_n, e.oe);
            cmp(e.tag, "we_n", we_n, e.we);
            cmp(e.tag, "sample", sample, e.smp);
            cmp(e.tag, "done", done, e.dn);
        end
    end

    task automatic push(input logic av, oe, we, smp, dn, input string tag);
        exp_t e;
        e = '{av:av, oe:oe, we:we, smp:smp, dn:dn, tag:tag};
        q.push_back(e);
    endtask

    // Driver: raise a request while idle and queue its expected pattern
    task automatic run_access(input logic [1:0] kind, input logic tc, input logic [3:0] w,
                              input logic [2:0] s0, h0, s1, h1, input string tag,
                              input bit scramble, input bit poke_done);
        int s, wd, h;
        bit rd, mrd;
        req_kind = kind; req_tc = tc; strobe_width = w;
        setup_code0 = s0; hold_code0 = h0; setup_code1 = s1; hold_code1 = h1;
        req_valid = 1'b1;
        rd  = !kind[0];
        mrd = rd && !kind[1];
        s   = dec(tc ? s1 : s0);
        h   = dec(tc ? h1 : h0);
        wd  = (w == 0) ? 1 : int'(w);
        if (mrd) h = (h > 0) ? h - 1 : 0;
        for (int i = 0; i < s; i++) push(1, 1, 1, 0, 0, tag);
        for (int i = 0; i < wd; i++) push(1, !rd, rd, rd && (i == wd - 1), 0, tag);
        for (int i = 0; i < h; i++) push(1, 1, 1, 0, 0, tag);
        push(0, 1, 1, 0, 1, tag);
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (scramble) begin
            req_kind = ~kind; req_tc = ~tc; strobe_width = ~w;
            setup_code0 = ~s0; hold_code0 = ~h0; setup_code1 = ~s1; hold_code1 = ~h1;
        end
        while (q.size() != 0) begin @(negedge clk); #1; end
        if (poke_done) begin
            idle_tag = "R9";
            req_valid = 1'b1;        // present only during the done cycle
            @(negedge clk); #1;
            req_valid = 1'b0;
            repeat (4) begin @(negedge clk); #1; end
            idle_tag = "R11";
        end else begin
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        mon_on = 1'b1;                      // R11: idle outputs checked in reset
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) begin @(negedge clk); #1; end   // R11: idle after reset
        // R1, R2: every setup code, memory write, set 0
        for (int c = 0; c < 8; c++)
            run_access(2'b01, 1'b0, 4'd2, 3'(c), 3'd1, 3'd0, 3'd0, "R2", 0, 0);
        // R3: set 1 chosen, set 0 differs
        run_access(2'b11, 1'b1, 4'd3, 3'd0, 3'd0, 3'd4, 3'd2, "R3", 0, 0);
        run_access(2'b11, 1'b0, 4'd3, 3'd2, 3'd5, 3'd7, 3'd7, "R3", 0, 0);
        // R4: width 0 acts as 1, longer widths
        run_access(2'b11, 1'b0, 4'd0, 3'd1, 3'd1, 3'd0, 3'd0, "R4", 0, 0);
        run_access(2'b10, 1'b0, 4'd7, 3'd0, 3'd1, 3'd0, 3'd0, "R4", 0, 0);
        // R5, R6: reads vs writes in both spaces
        run_access(2'b00, 1'b0, 4'd4, 3'd3, 3'd2, 3'd0, 3'd0, "R6", 0, 0);
        run_access(2'b01, 1'b1, 4'd4, 3'd0, 3'd0, 3'd1, 3'd2, "R5", 0, 0);
        // R7: hold after release, I/O read and memory write, all codes
        for (int c = 0; c < 8; c++)
            run_access(2'b10, 1'b1, 4'd1, 3'd0, 3'd0, 3'd1, 3'(c), "R7", 0, 0);
        run_access(2'b01, 1'b0, 4'd2, 3'd0, 3'd6, 3'd0, 3'd0, "R7", 0, 0);
        // R8: memory read hold counted from sample cycle
        for (int c = 0; c < 5; c++)
            run_access(2'b00, 1'b0, 4'd2, 3'd1, 3'(c), 3'd0, 3'd0, "R8", 0, 0);
        // R10: inputs scrambled during the access
        run_access(2'b00, 1'b1, 4'd3, 3'd0, 3'd0, 3'd2, 3'd3, "R10", 1, 0);
        run_access(2'b11, 1'b0, 4'd5, 3'd4, 3'd1, 3'd3, 3'd0, "R10", 1, 0);
        // R9: request during done ignored, then back-to-back acceptance
        run_access(2'b10, 1'b0, 4'd2, 3'd1, 3'd2, 3'd0, 3'd0, "R9", 0, 1);
        run_access(2'b01, 1'b0, 4'd1, 3'd0, 3'd0, 3'd0, 3'd0, "R9", 0, 0);
        run_access(2'b00, 1'b0, 4'd1, 3'd0, 3'd0, 3'd0, 3'd0, "R9", 0, 0);
        repeat (2) @(negedge clk);
        #1 mon_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule